// File: doc/BRIEF.md
# USB Root-Port Reset, Suspend and Resume Controller

This block is the host-side control state machine that sits behind the reset, suspend and force-resume bits of a USB root-port status/control register. Software writes the register through a write strobe with three data bits. The block times the bus reset and the resume signalling itself, and it clears those bits when each sequence ends, so the driver never has to time them. It also watches the line state while the port is suspended. A J-to-K transition on the line starts a resume and raises a one-cycle port-change pulse.

The port has six internal states: disabled, in reset, enabled, suspend pending, suspended and resuming. The readable bits are decoded from this state and gated by port power. While the port is suspended or resuming, the block raises a downstream-block signal. It also asks the line driver for SE0 during a reset and for K during a resume. Both durations are parameters given in clock cycles.

Top module: `usb_port_ctl`

## Requirements
- R1: A register write with `wdata_rst`=1 while powered puts the port in reset. `rst_bit` reads 1 from the next cycle for exactly `RST_CYCLES` cycles and then clears by itself, leaving `pe`=1 and `susp_bit`=0. A reset write is accepted in any powered state, including suspend.
- R2: `susp_bit`=1 implies `pe`=1. A write that sets the suspend bit while `pe`=0 is dropped, and the port stays disabled.
- R3: A suspend request made while `xact_busy`=1 leaves `susp_bit` and `block_ds` at 0 until `xact_end` is seen. From the cycle after that strobe, both read 1.
- R4: A suspend request while enabled and idle sets `susp_bit` and `block_ds` from the next cycle. While suspended, downstream traffic stays blocked.
- R5: While suspended, a J state (`line_st`=2'b01) followed in the next cycle by a K state (`line_st`=2'b10) sets `res_bit` and raises `pcd` in the following cycle.
- R6: A write with `wdata_res`=1 while suspended starts a resume without a `pcd`. Every resume holds `res_bit` at 1 for exactly `RSM_CYCLES` cycles. After that, `res_bit` and `susp_bit` both clear and `pe` stays 1.
- R7: Writing 0 to any of the three bits has no effect. A write of `wdata_res`=1 while the port is not suspended is also ignored.
- R8: With `pwr`=0, `rst_bit`, `susp_bit`, `res_bit` and `pe` read 0 in the same cycle. Losing power aborts a running reset or resume timer, and the port is disabled when power returns.
- R9: `pcd` is a one-cycle pulse.
- R10: `drive_se0` equals `rst_bit`, and `drive_k` equals `res_bit`.
- R11: `pe_clr` disables an enabled or suspended port, but it does not cut short a reset in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr | input | 1 | Port power |
| pe_clr | input | 1 | Software port-disable strobe |
| reg_wr | input | 1 | Register write strobe |
| wdata_rst | input | 1 | Written value of the reset bit |
| wdata_susp | input | 1 | Written value of the suspend bit |
| wdata_res | input | 1 | Written value of the force-resume bit |
| line_st | input | 2 | Line state: 00 SE0, 01 J, 10 K |
| xact_busy | input | 1 | A transaction is in progress |
| xact_end | input | 1 | Transaction-end strobe |
| pe | output | 1 | Port enabled |
| rst_bit | output | 1 | Reset bit read value |
| susp_bit | output | 1 | Suspend bit read value |
| res_bit | output | 1 | Force-resume bit read value |
| pcd | output | 1 | Port-change-detect pulse |
| drive_se0 | output | 1 | Request to drive reset SE0 |
| drive_k | output | 1 | Request to drive resume K |
| block_ds | output | 1 | Block downstream traffic |

## Verification
The bench counts how many cycles the reset bit and the resume bit stay high. An off-by-one in the timer would show up as one cycle too many or too few. It sends a suspend request while a transaction is still in progress and checks that blocking starts only after the end strobe, so a design that suspends at once fails this check. It checks that a J-to-K edge gives exactly one change pulse, and that a resume started by software gives none. It drops power in the middle of a reset to confirm that the timer is aborted rather than resumed. It also writes zeros, and sets suspend while disabled, to catch a design that lets those writes alter the state.

// File: rtl/usb_port_ctl.sv
module usb_port_ctl #(
  parameter int RST_CYCLES = 2_500_000,
  parameter int RSM_CYCLES = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr,
  input  logic       pe_clr,
  input  logic       reg_wr,
  input  logic       wdata_rst,
  input  logic       wdata_susp,
  input  logic       wdata_res,
  input  logic [1:0] line_st,
  input  logic       xact_busy,
  input  logic       xact_end,
  output logic       pe,
  output logic       rst_bit,
  output logic       susp_bit,
  output logic       res_bit,
  output logic       pcd,
  output logic       drive_se0,
  output logic       drive_k,
  output logic       block_ds
);
  localparam int MAXC = (RST_CYCLES > RSM_CYCLES) ? RST_CYCLES : RSM_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RST_LOAD = CW'(RST_CYCLES - 1);
  localparam logic [CW-1:0] RSM_LOAD = CW'(RSM_CYCLES - 1);
  localparam logic [1:0] LINE_J = 2'b01;
  localparam logic [1:0] LINE_K = 2'b10;

  typedef enum logic [2:0] {S_DIS, S_RST, S_EN, S_PEND, S_SUSP, S_RSM} st_t;

  st_t st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [1:0] line_q;
  logic pcd_n;

  wire jk_edge = (line_q == LINE_J) && (line_st == LINE_K);
  wire cnt_done = (cnt == '0);

  always_comb begin
    st_n  = st;
    cnt_n = cnt_done ? cnt : cnt - 1'b1;
    pcd_n = 1'b0;
    if (!pwr) begin
      st_n  = S_DIS;
      cnt_n = '0;
    end else if (reg_wr && wdata_rst) begin
      st_n  = S_RST;
      cnt_n = RST_LOAD;
    end else if (pe_clr && st != S_RST) begin
      st_n  = S_DIS;
      cnt_n = '0;
    end else begin
      case (st)
        S_RST:  if (cnt_done) st_n = S_EN;
        S_EN:   if (reg_wr && wdata_susp) st_n = xact_busy ? S_PEND : S_SUSP;
        S_PEND: if (xact_end) st_n = S_SUSP;
        S_SUSP: if (jk_edge || (reg_wr && wdata_res)) begin
                  st_n  = S_RSM;
                  cnt_n = RSM_LOAD;
                  pcd_n = jk_edge;
                end
        S_RSM:  if (cnt_done) st_n = S_EN;
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_DIS;
      cnt    <= '0;
      line_q <= 2'b00;
      pcd    <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      line_q <= line_st;
      pcd    <= pcd_n;
    end
  end

  assign rst_bit   = pwr && (st == S_RST);
  assign res_bit   = pwr && (st == S_RSM);
  assign susp_bit  = pwr && (st == S_SUSP || st == S_RSM);
  assign pe        = pwr && (st == S_EN || st == S_PEND || st == S_SUSP || st == S_RSM);
  assign block_ds  = pwr && (st == S_SUSP || st == S_RSM);
  assign drive_se0 = rst_bit;
  assign drive_k   = res_bit;

  p_nopower_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |-> !rst_bit && !susp_bit && !res_bit && !pe);
  p_susp_pe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    susp_bit |-> pe);
  p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    susp_bit |-> block_ds);
  p_pcd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pcd |=> !pcd);
  p_pcd_res_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pcd && pwr |-> res_bit);
  p_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_se0 == rst_bit) && (drive_k == res_bit));
  p_reset_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_bit) && pwr && $past(pwr) && !$past(reg_wr && wdata_rst) |-> pe && !susp_bit);
  p_res_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_bit) && pwr && $past(pwr) && !$past(pe_clr) && !$past(reg_wr && wdata_rst)
    |-> pe && !susp_bit);
  p_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_ds) && pwr && $past(pwr) && $past(pe) |-> $past(!xact_busy || xact_end));
endmodule

// File: tb/test_usb_port_ctl.sv
module test_usb_port_ctl;
  localparam int RST_C = 8;
  localparam int RSM_C = 5;

  logic clk = 0, rst_n = 0, pwr = 1, pe_clr = 0, reg_wr = 0;
  logic wdata_rst = 0, wdata_susp = 0, wdata_res = 0;
  logic [1:0] line_st = 2'b01;
  logic xact_busy = 0, xact_end = 0;
  logic pe, rst_bit, susp_bit, res_bit, pcd, drive_se0, drive_k, block_ds;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  usb_port_ctl #(.RST_CYCLES(RST_C), .RSM_CYCLES(RSM_C)) i_usb_port_ctl (
    .clk(clk), .rst_n(rst_n), .pwr(pwr), .pe_clr(pe_clr), .reg_wr(reg_wr),
    .wdata_rst(wdata_rst), .wdata_susp(wdata_susp), .wdata_res(wdata_res),
    .line_st(line_st), .xact_busy(xact_busy), .xact_end(xact_end),
    .pe(pe), .rst_bit(rst_bit), .susp_bit(susp_bit), .res_bit(res_bit), .pcd(pcd),
    .drive_se0(drive_se0), .drive_k(drive_k), .block_ds(block_ds));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic r, input logic s, input logic f);
    @(negedge clk);
    reg_wr = 1; wdata_rst = r; wdata_susp = s; wdata_res = f;
    @(negedge clk);
    reg_wr = 0; wdata_rst = 0; wdata_susp = 0; wdata_res = 0;
  endtask

  task automatic count_high(ref logic sig, output int n);
    n = 0;
    while (sig && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    chk("R1 reset pr", rst_bit, 0);
    chk("R2 reset pe", pe, 0);
    chk("R6 reset fpr", res_bit, 0);
    chk("R9 reset pcd", pcd, 0);
  endtask

  task automatic t_susp_disabled();
    wr(0, 1, 0);
    chk("R2 susp while disabled", susp_bit, 0);
    chk("R2 stays disabled", pe, 0);
  endtask

  task automatic t_port_reset();
    int n;
    wr(1, 0, 0);
    chk("R10 se0 during reset", drive_se0, 1);
    count_high(rst_bit, n);
    chk("R1 reset length", n, RST_C);
    chk("R1 pe after reset", pe, 1);
    chk("R1 susp after reset", susp_bit, 0);
  endtask

  task automatic t_res_when_enabled();
    wr(0, 0, 1);
    chk("R7 fpr write while enabled", res_bit, 0);
  endtask

  task automatic t_suspend_idle();
    wr(0, 1, 0);
    chk("R4 susp set", susp_bit, 1);
    chk("R4 blocked", block_ds, 1);
    wr(0, 0, 0);
    chk("R7 write zero keeps susp", susp_bit, 1);
  endtask

  task automatic t_jk_resume();
    int n;
    @(negedge clk); line_st = 2'b01;
    @(negedge clk); line_st = 2'b10;
    @(negedge clk);
    chk("R5 pcd on J-K", pcd, 1);
    chk("R5 fpr on J-K", res_bit, 1);
    chk("R10 drive_k", drive_k, 1);
    @(negedge clk);
    chk("R9 pcd one cycle", pcd, 0);
    count_high(res_bit, n);
    chk("R6 resume length (hw)", n, RSM_C - 1);
    chk("R6 susp cleared", susp_bit, 0);
    chk("R6 pe kept", pe, 1);
    line_st = 2'b01;
  endtask

  task automatic t_sw_resume();
    int n;
    wr(0, 1, 0);
    wr(0, 0, 1);
    chk("R6 sw resume no pcd", pcd, 0);
    count_high(res_bit, n);
    chk("R6 resume length (sw)", n, RSM_C);
    chk("R6 susp cleared sw", susp_bit, 0);
  endtask

  task automatic t_pending();
    @(negedge clk); xact_busy = 1;
    wr(0, 1, 0);
    repeat (3) begin
      chk("R3 susp waits", susp_bit, 0);
      chk("R3 not blocked yet", block_ds, 0);
      @(negedge clk);
    end
    xact_end = 1; xact_busy = 0;
    @(negedge clk); xact_end = 0;
    chk("R3 susp after end", susp_bit, 1);
    chk("R3 blocked after end", block_ds, 1);
  endtask

  task automatic t_reset_from_susp();
    int n;
    wr(1, 0, 0);
    chk("R4 reset accepted in suspend", rst_bit, 1);
    count_high(rst_bit, n);
    chk("R1 reset length from suspend", n, RST_C);
    chk("R1 susp cleared by reset", susp_bit, 0);
  endtask

  task automatic t_power_drop();
    wr(1, 0, 0);
    @(negedge clk); pwr = 0; #1;
    chk("R8 pr gated", rst_bit, 0);
    chk("R8 pe gated", pe, 0);
    @(negedge clk); @(negedge clk); pwr = 1; #1;
    chk("R8 reset aborted", rst_bit, 0);
    chk("R8 disabled after power", pe, 0);
  endtask

  task automatic t_pe_clr();
    int n;
    wr(1, 0, 0);
    @(negedge clk); pe_clr = 1;
    @(negedge clk); pe_clr = 0;
    chk("R11 pe_clr ignored in reset", rst_bit, 1);
    count_high(rst_bit, n);
    wr(0, 1, 0);
    @(negedge clk); pe_clr = 1;
    @(negedge clk); pe_clr = 0;
    chk("R11 pe cleared", pe, 0);
    chk("R11 susp cleared", susp_bit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_susp_disabled();
    t_port_reset();
    t_res_when_enabled();
    t_suspend_idle();
    t_jk_resume();
    t_sw_resume();
    t_pending();
    t_reset_from_susp();
    t_power_drop();
    t_pe_clr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule